// File: doc/BRIEF.md
# Main Clock Loss Monitor

This block runs from an independent internal oscillator clock and watches the main oscillator clock, treating it as data. The main clock passes through a synchronizer into the internal-oscillator domain. An edge detector then feeds a missing-edge counter. If the main clock stops toggling for a programmable number of internal-oscillator cycles while monitoring is active, a sticky loss fault is raised. A neighbouring block can turn that fault into an interrupt or a reset request.

Monitoring is suspended on its own in several cases: while stop mode is requested, while the oscillation-stabilization window that follows stop mode is still being counted, while the system runs from the subclock, and while the main clock is deliberately halted. It resumes without software action once the condition clears. When the CPU runs from the internal oscillator, none of these conditions suspends monitoring. Software sets the enable once, and only a reset clears it. The missing-edge counter is held at zero during any suspension, so resuming never raises a false fault.

Top module: `mclk_watch`

## Requirements
- R1: During reset and after its release, before any enable, `mon_active` is 0 and `loss_fault` is 0.
- R2: A one-cycle pulse on `mon_en_set` sets the monitor enable permanently. Holding `mon_en_set` at 0 afterwards does not clear it, and only `rst_n` does.
- R3: While monitoring is active, `loss_fault` rises after MISS_LIMIT consecutive internal-oscillator cycles without a synchronized main-clock edge. If the main clock toggles every g internal cycles, a fault occurs exactly when g >= MISS_LIMIT+1.
- R4: Once set, `loss_fault` stays 1 until reset, even if the main clock restarts or monitoring is suspended.
- R5: From the cycle after `stop_req` goes high, monitoring is suspended (`mon_active` = 0) for as long as `stop_req` stays high, unless `cpu_on_iosc` is 1.
- R6: After `stop_req` falls, monitoring stays suspended until `ost_done` is seen high. Monitoring then resumes automatically and stays active when `ost_done` later falls.
- R7: While `subclk_sel` = 1 or `main_halt` = 1, monitoring is suspended. It resumes as soon as both are 0.
- R8: While `cpu_on_iosc` = 1, no suspension condition applies. An enabled monitor stays active and still detects a stopped main clock.
- R9: The missing-edge counter is cleared while monitoring is inactive. A main clock that was stopped only during a suspension, or before the enable, raises no fault.
- R10: `mon_active` is 1 exactly when the enable is set and no suspension condition applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| main_clk | input | 1 | Monitored main clock, sampled as data |
| mon_en_set | input | 1 | Write-once monitor enable pulse |
| stop_req | input | 1 | Stop mode is in effect |
| ost_done | input | 1 | Oscillation-stabilization time has elapsed |
| subclk_sel | input | 1 | System runs from the subclock |
| main_halt | input | 1 | Main clock deliberately halted |
| cpu_on_iosc | input | 1 | CPU runs from the internal oscillator (suspension override) |
| mon_active | output | 1 | Monitoring is enabled and not suspended |
| loss_fault | output | 1 | Sticky main-clock loss fault |

## Verification
The bench builds the block with MISS_LIMIT = 3 and the default two-stage synchronizer. This small limit makes the full edge-gap threshold reachable with short runs. The bench sweeps main-clock toggle gaps from 1 to 6 internal cycles, which lands on both sides of the g = MISS_LIMIT+1 boundary. With the same small limit, every suspension path (stop, stabilization window, subclock, halt) can be held far longer than the limit, and resumption can be checked to stay fault-free.

// File: rtl/mclk_watch_pkg.sv
package mclk_watch_pkg;

  // Low-power window tracking: running, stopped, waiting for stabilization
  typedef enum logic [1:0] {
    WIN_RUN  = 2'd0,
    WIN_STOP = 2'd1,
    WIN_STAB = 2'd2
  } win_state_e;

endpackage

// File: rtl/mclk_sync.sv
module mclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n[0] = async_i;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_comb begin
        chain_n[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/mclk_susp_ctl.sv
module mclk_susp_ctl
  import mclk_watch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_set_i,
  input  logic stop_req_i,
  input  logic ost_done_i,
  input  logic subclk_i,
  input  logic halt_i,
  input  logic iosc_i,
  output logic en_o,
  output logic in_window_o,
  output logic active_o
);

  win_state_e state_q;
  win_state_e state_n;
  logic       en_q;
  logic       en_n;
  logic       suspend;

  // Enable: write-once, cleared only by reset
  always_comb begin
    en_n = en_q;
    if (en_set_i) begin
      en_n = 1'b1;
    end
  end

  // Stop / stabilization window tracking
  always_comb begin
    state_n = state_q;
    case (state_q)
      WIN_RUN: begin
        if (stop_req_i) state_n = WIN_STOP;
      end
      WIN_STOP: begin
        if (!stop_req_i) state_n = WIN_STAB;
      end
      WIN_STAB: begin
        if (stop_req_i)      state_n = WIN_STOP;
        else if (ost_done_i) state_n = WIN_RUN;
      end
      default: state_n = WIN_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_RUN;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      en_q    <= en_n;
    end
  end

  assign in_window_o = (state_q != WIN_RUN);
  assign suspend     = !iosc_i && (in_window_o || subclk_i || halt_i);
  assign en_o        = en_q;
  assign active_o    = en_q && !suspend;

endmodule

// File: rtl/mclk_edge_miss.sv
module mclk_edge_miss #(
  parameter int MISS_LIMIT = 4,
  localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             active_i,
  output logic [CNT_W-1:0] miss_cnt_o,
  output logic             edge_o,
  output logic             fault_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_LIMIT - 1);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             fault_q;
  logic             fault_n;
  logic             tick_edge;

  assign tick_edge = sync_i ^ prev_q;

  always_comb begin
    cnt_n   = cnt_q;
    fault_n = fault_q;
    if (!active_i || tick_edge) begin
      cnt_n = '0;
    end else if (cnt_q == LAST) begin
      cnt_n   = '0;
      fault_n = 1'b1;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      cnt_q   <= cnt_n;
      fault_q <= fault_n;
    end
  end

  assign miss_cnt_o = cnt_q;
  assign edge_o     = tick_edge;
  assign fault_o    = fault_q;

endmodule

// File: rtl/mclk_watch.sv
module mclk_watch #(
  parameter int MISS_LIMIT  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic main_clk,
  input  logic mon_en_set,
  input  logic stop_req,
  input  logic ost_done,
  input  logic subclk_sel,
  input  logic main_halt,
  input  logic cpu_on_iosc,
  output logic mon_active,
  output logic loss_fault
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             main_sync;
  logic             en_q;
  logic             in_window;
  logic             seen_edge;
  logic [CNT_W-1:0] miss_cnt;

  // Reset: asynchronous assertion, synchronous release
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  mclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (ref_clk),
    .rst_n   (rst_int_n),
    .async_i (main_clk),
    .sync_o  (main_sync)
  );

  mclk_susp_ctl u_ctl (
    .clk         (ref_clk),
    .rst_n       (rst_int_n),
    .en_set_i    (mon_en_set),
    .stop_req_i  (stop_req),
    .ost_done_i  (ost_done),
    .subclk_i    (subclk_sel),
    .halt_i      (main_halt),
    .iosc_i      (cpu_on_iosc),
    .en_o        (en_q),
    .in_window_o (in_window),
    .active_o    (mon_active)
  );

  mclk_edge_miss #(.MISS_LIMIT(MISS_LIMIT)) u_miss (
    .clk        (ref_clk),
    .rst_n      (rst_int_n),
    .sync_i     (main_sync),
    .active_i   (mon_active),
    .miss_cnt_o (miss_cnt),
    .edge_o     (seen_edge),
    .fault_o    (loss_fault)
  );

endmodule

// File: rtl/mclk_watch_chk.sv
module mclk_watch_chk #(
  parameter int MISS_LIMIT = 4,
  localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
  input logic             ref_clk,
  input logic             rst_int_n,
  input logic             stop_req,
  input logic             cpu_on_iosc,
  input logic             mon_active,
  input logic             loss_fault,
  input logic             en_q,
  input logic             in_window,
  input logic             seen_edge,
  input logic [CNT_W-1:0] miss_cnt
);

  // R2: enable never clears once set
  a_r2_enable_holds: assert property (@(posedge ref_clk) disable iff (!rst_int_n)
    en_q |=> en_q);

  // R4: fault is sticky
  a_r4_fault_sticky: assert property (@(posedge ref_clk) disable iff (!rst_int_n)
    loss_fault |=> loss_fault);

  // R9: no fault can be raised by an inactive monitor
  a_r9_no_raise_inactive: assert property (@(posedge ref_clk) disable iff (!rst_int_n)
    !mon_active |=> !$rose(loss_fault));

  // R9: counter cleared after an inactive cycle
  a_r9_cnt_cleared: assert property (@(posedge ref_clk) disable iff (!rst_int_n)
    !mon_active |=> (miss_cnt == '0));

  // R3: an edge restarts the count
  a_r3_edge_restarts: assert property (@(posedge ref_clk) disable iff (!rst_int_n)
    seen_edge |=> (miss_cnt == '0));

  // R3: counter stays below the limit
  a_r3_cnt_bound: assert property (@(posedge ref_clk) disable iff (!rst_int_n)
    miss_cnt < CNT_W'(MISS_LIMIT));

  // R5: stop request suspends from the next cycle unless overridden
  a_r5_stop_suspends: assert property (@(posedge ref_clk) disable iff (!rst_int_n)
    stop_req |=> (in_window && (!mon_active || cpu_on_iosc)));

endmodule

bind mclk_watch mclk_watch_chk #(.MISS_LIMIT(MISS_LIMIT)) u_chk (
  .ref_clk     (ref_clk),
  .rst_int_n   (rst_int_n),
  .stop_req    (stop_req),
  .cpu_on_iosc (cpu_on_iosc),
  .mon_active  (mon_active),
  .loss_fault  (loss_fault),
  .en_q        (en_q),
  .in_window   (in_window),
  .seen_edge   (seen_edge),
  .miss_cnt    (miss_cnt)
);

// File: tb/tb_mclk_watch.sv
`timescale 1ns/1ps
module tb_mclk_watch;

  localparam int LIMIT = 3;

  logic ref_clk;
  logic rst_n;
  logic main_clk;
  logic mon_en_set;
  logic stop_req;
  logic ost_done;
  logic subclk_sel;
  logic main_halt;
  logic cpu_on_iosc;
  logic mon_active;
  logic loss_fault;

  int n_checks;
  int n_fail;
  int mc_gap;
  int mc_cnt;

  mclk_watch #(.MISS_LIMIT(LIMIT), .SYNC_STAGES(2)) dut (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .main_clk    (main_clk),
    .mon_en_set  (mon_en_set),
    .stop_req    (stop_req),
    .ost_done    (ost_done),
    .subclk_sel  (subclk_sel),
    .main_halt   (main_halt),
    .cpu_on_iosc (cpu_on_iosc),
    .mon_active  (mon_active),
    .loss_fault  (loss_fault)
  );

  initial ref_clk = 1'b0;
  always #5 ref_clk = ~ref_clk;

  // Main clock model: toggles every mc_gap internal cycles, holds when 0
  initial begin
    main_clk = 1'b0;
    mc_cnt   = 0;
    mc_gap   = 0;
  end
  always @(negedge ref_clk) begin
    if (mc_gap == 0) begin
      mc_cnt <= 0;
    end else if (mc_cnt + 1 >= mc_gap) begin
      mc_cnt   <= 0;
      main_clk <= ~main_clk;
    end else begin
      mc_cnt <= mc_cnt + 1;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n       = 1'b0;
    mon_en_set  = 1'b0;
    stop_req    = 1'b0;
    ost_done    = 1'b0;
    subclk_sel  = 1'b0;
    main_halt   = 1'b0;
    cpu_on_iosc = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
  endtask

  task automatic pulse_enable();
    mon_en_set = 1'b1;
    wait_n(1);
    mon_en_set = 1'b0;
    wait_n(1);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    @(negedge ref_clk);

    // R1: reset state
    rst_n = 1'b0;
    mon_en_set = 1'b0; stop_req = 1'b0; ost_done = 1'b0;
    subclk_sel = 1'b0; main_halt = 1'b0; cpu_on_iosc = 1'b0;
    wait_n(2);
    check("R1 active in reset", mon_active, 1'b0);
    check("R1 fault in reset", loss_fault, 1'b0);
    rst_n = 1'b1;
    wait_n(30);
    check("R1 active after reset", mon_active, 1'b0);
    check("R9 no fault before enable", loss_fault, 1'b0);

    // R3: sweep of main-clock toggle gaps
    for (int g = 1; g <= 6; g++) begin
      do_reset();
      mc_gap = g;
      wait_n(12);
      pulse_enable();
      check("R10 active after enable", mon_active, 1'b1);
      wait_n(40);
      check("R3 gap sweep", loss_fault, (g >= LIMIT + 1) ? 1'b1 : 1'b0);
    end

    // R2 + R4: write-once enable, sticky fault
    do_reset();
    mc_gap = 2;
    wait_n(12);
    pulse_enable();
    wait_n(25);
    check("R2 enable held", mon_active, 1'b1);
    check("R3 no fault on running clock", loss_fault, 1'b0);
    mc_gap = 0;
    wait_n(10);
    check("R3 stopped clock faults", loss_fault, 1'b1);
    mc_gap = 2;
    wait_n(20);
    check("R4 fault sticky after restart", loss_fault, 1'b1);
    main_halt = 1'b1;
    wait_n(5);
    check("R4 fault sticky when suspended", loss_fault, 1'b1);
    main_halt = 1'b0;

    // R5 + R6: stop mode and stabilization window
    do_reset();
    mc_gap = 2;
    wait_n(12);
    pulse_enable();
    wait_n(10);
    stop_req = 1'b1;
    wait_n(2);
    check("R5 stop suspends", mon_active, 1'b0);
    mc_gap = 0;
    wait_n(40);
    check("R5 no fault during stop", loss_fault, 1'b0);
    stop_req = 1'b0;
    wait_n(2);
    check("R6 stab window suspends", mon_active, 1'b0);
    wait_n(30);
    check("R6 no fault in stab window", loss_fault, 1'b0);
    mc_gap = 2;
    wait_n(10);
    ost_done = 1'b1;
    wait_n(2);
    check("R6 resumes on done", mon_active, 1'b1);
    ost_done = 1'b0;
    wait_n(40);
    check("R6 stays active after done falls", mon_active, 1'b1);
    check("R9 no fault after stop resume", loss_fault, 1'b0);
    mc_gap = 0;
    wait_n(10);
    check("R6 resumed monitor detects loss", loss_fault, 1'b1);

    // R7 + R9: main clock halt
    do_reset();
    mc_gap = 2;
    wait_n(12);
    pulse_enable();
    wait_n(10);
    main_halt = 1'b1;
    wait_n(2);
    check("R7 halt suspends", mon_active, 1'b0);
    mc_gap = 0;
    wait_n(50);
    check("R9 no fault during halt", loss_fault, 1'b0);
    mc_gap = 2;
    wait_n(10);
    main_halt = 1'b0;
    wait_n(1);
    check("R7 halt resume", mon_active, 1'b1);
    wait_n(40);
    check("R9 no fault after halt resume", loss_fault, 1'b0);

    // R7: subclock operation
    do_reset();
    mc_gap = 2;
    wait_n(12);
    pulse_enable();
    wait_n(10);
    subclk_sel = 1'b1;
    wait_n(2);
    check("R7 subclock suspends", mon_active, 1'b0);
    mc_gap = 0;
    wait_n(50);
    check("R7 no fault on subclock", loss_fault, 1'b0);
    mc_gap = 2;
    wait_n(10);
    subclk_sel = 1'b0;
    wait_n(1);
    check("R7 subclock resume", mon_active, 1'b1);
    wait_n(40);
    check("R9 no fault after subclock resume", loss_fault, 1'b0);

    // R8: internal oscillator override
    do_reset();
    mc_gap = 2;
    wait_n(12);
    pulse_enable();
    subclk_sel  = 1'b1;
    cpu_on_iosc = 1'b1;
    wait_n(3);
    check("R8 override keeps active", mon_active, 1'b1);
    stop_req = 1'b1;
    wait_n(3);
    check("R8 override during stop", mon_active, 1'b1);
    mc_gap = 0;
    wait_n(15);
    check("R8 override detects loss", loss_fault, 1'b1);
    stop_req    = 1'b0;
    cpu_on_iosc = 1'b0;
    wait_n(2);
    check("R10 suspension back without override", mon_active, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule